// File: doc/BRIEF.md
# Self-Correcting One-Hot Ring Counter

This block keeps a single active bit circulating around an n-bit register, 8 bits wide by default. Each flip-flop output serves as the decoded output for one state. Because exactly one flop is high in every legal state, the decoded outputs come straight from registers, and no combinational decoder can glitch them. Typical uses are timing-sequence and phase-select generation in control logic.

The register shifts toward the MSB on every enabled clock, and a serial bit enters at bit 0. The register is split into equal slices that are chained one after another. When correction is enabled, the serial bit is the NOR of every bit below the MSB. From any pattern, including all zeros or several ones, the counter then reaches a one-hot state within n−1 enabled clocks and remains one-hot after that. When correction is disabled, the serial bit is the MSB, so any pattern loaded through the parallel port rotates unchanged. A flag reports whether the current state holds exactly one set bit.

Top module: `onehot_ring_counter`

## Requirements
- R1: A synchronous reset sets `q` to the value with only bit 0 set, and it overrides `load` and `en` in the same cycle.
- R2: With `en` high and `load` low, each clock moves bit i of `q` into bit i+1 and drops the old MSB, and the serial bit enters bit 0.
- R3: With `corr_en` high, the serial bit is 1 exactly when bits 0 to WIDTH−2 are all 0. Starting from reset, `q` therefore visits bit 0, bit 1, …, bit WIDTH−1 and wraps back to bit 0, with one bit set in every state.
- R4: With `corr_en` and `en` high, every start pattern (all 2^WIDTH values) becomes one-hot within WIDTH−1 clocks and stays one-hot on later clocks.
- R5: With `en` and `load` both low, `q` holds its value.
- R6: With `load` high, `q` takes `load_data` on the next clock, whatever the value of `en`, so loading takes priority over shifting.
- R7: `one_hot_valid` is high exactly when `q` has one bit set. It is combinational from `q`.
- R8: With `corr_en` low, the serial bit equals the old MSB, so the number of set bits is preserved and a loaded pattern returns after WIDTH shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Shift enable |
| load | input | 1 | Parallel load strobe |
| load_data | input | WIDTH | Pattern to load |
| corr_en | input | 1 | Selects the NOR feedback (1) or plain MSB rotate (0) |
| q | output | WIDTH | Counter state, one decoded output per bit |
| one_hot_valid | output | 1 | High when exactly one bit of `q` is set |

## Verification
A parallel load and a shift can be requested in the same cycle, and the load must win. Every one of the 256 patterns is loaded with `en` held high in that same cycle, and the bench checks that `q` equals the loaded pattern rather than its shifted image. It also drives reset and load together and checks that the reset value wins. After each load, the pattern is shifted under both feedback modes, and every step is compared with an arithmetically computed next state. The bench checks convergence to one-hot by the (WIDTH−1)th shift.

// File: rtl/onehot_ring_counter.sv
module onehot_ring_counter #(
  parameter int WIDTH = 8,
  parameter int SLICE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_data,
  input  logic             corr_en,
  output logic [WIDTH-1:0] q,
  output logic             one_hot_valid
);
  localparam int NSLICE = WIDTH / SLICE;

  logic             fb;
  logic [WIDTH-1:0] shifted;
  logic [SLICE-1:0] stg [NSLICE];

  assign fb      = corr_en ? ~|q[WIDTH-2:0] : q[WIDTH-1];
  assign shifted = {q[WIDTH-2:0], fb};

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    localparam int LO = g * SLICE;
    localparam logic [SLICE-1:0] RST_V = (g == 0) ? SLICE'(1) : '0;

    always_ff @(posedge clk) begin
      if (rst)       stg[g] <= RST_V;
      else if (load) stg[g] <= load_data[LO +: SLICE];
      else if (en)   stg[g] <= shifted[LO +: SLICE];
    end

    assign q[LO +: SLICE] = stg[g];
  end

  assign one_hot_valid = (q != '0) && ((q & (q - 1'b1)) == '0);
endmodule

module onehot_ring_counter_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             load,
  input logic [WIDTH-1:0] load_data,
  input logic             corr_en,
  input logic [WIDTH-1:0] q,
  input logic             one_hot_valid
);
  logic [$clog2(WIDTH)+1:0] bad_run;

  always_ff @(posedge clk) begin
    if (rst) bad_run <= '0;
    else if (load || one_hot_valid || (en && !corr_en)) bad_run <= '0;
    else if (en && corr_en) bad_run <= bad_run + 1'b1;
  end

  // R1
  reset_value_chk: assert property (@(posedge clk) rst |=> q == WIDTH'(1));
  // R2
  shift_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));
  // R3
  legal_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load && corr_en && one_hot_valid) |=> one_hot_valid);
  // R4
  converge_chk: assert property (@(posedge clk) disable iff (rst)
    bad_run <= ($clog2(WIDTH)+2)'(WIDTH-1));
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(q));
  // R6
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(load_data));
  // R7
  valid_flag_chk: assert property (@(posedge clk) disable iff (rst)
    one_hot_valid == ($countones(q) == 1));
  // R8
  weight_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !load && !corr_en) |=> $countones(q) == $past($countones(q)));
endmodule

bind onehot_ring_counter onehot_ring_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/onehot_ring_counter_tb.sv
module onehot_ring_counter_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst, en, load, corr_en;
  logic [W-1:0] load_data;
  logic [W-1:0] q;
  logic         one_hot_valid;
  int           n_tests = 0;
  int           n_fail  = 0;

  onehot_ring_counter #(.WIDTH(W), .SLICE(4)) u_dut (
    .clk(clk), .rst(rst), .en(en), .load(load), .load_data(load_data),
    .corr_en(corr_en), .q(q), .one_hot_valid(one_hot_valid)
  );

  always #5 clk = ~clk;

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int ones(input int v);
    int c = 0;
    for (int i = 0; i < W; i++) c += (v >> i) & 1;
    return c;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  int exp_s;

  initial begin
    rst = 1; en = 0; load = 0; corr_en = 1; load_data = '0;
    @(negedge clk); tick(); tick();
    chk("R1 reset value", q, 1);
    chk("R7 valid after reset", one_hot_valid, 1);

    rst = 0; en = 1;
    for (int k = 1; k <= 2 * W; k++) begin
      tick();
      chk("R3 one-hot sequence", q, 1 << (k % W));
      chk("R2 shift", one_hot_valid, 1);
    end

    en = 0;
    exp_s = q;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5 hold", q, exp_s);
    end

    for (int p = 0; p < (1 << W); p++) begin
      load = 1; en = 1; corr_en = 1; load_data = W'(p);
      tick();
      chk("R6 load wins over shift", q, p);
      chk("R7 valid flag", one_hot_valid, int'(ones(p) == 1));
      load = 0;
      exp_s = p;
      for (int k = 1; k <= W; k++) begin
        exp_s = ((exp_s << 1) & ((1 << W) - 1)) | int'((exp_s % (1 << (W - 1))) == 0);
        tick();
        chk("R2 R3 corrected step", q, exp_s);
        chk("R7 valid flag", one_hot_valid, int'(ones(exp_s) == 1));
        if (k >= W - 1) chk("R4 converged", one_hot_valid, 1);
      end
    end

    corr_en = 0;
    for (int p = 0; p < (1 << W); p++) begin
      load = 1; en = 0; load_data = W'(p);
      tick();
      chk("R6 load with en low", q, p);
      load = 0; en = 1;
      exp_s = p;
      for (int k = 1; k <= W; k++) begin
        exp_s = ((exp_s << 1) & ((1 << W) - 1)) | (exp_s >> (W - 1));
        tick();
        chk("R8 rotate step", q, exp_s);
      end
      chk("R8 pattern returns", q, p);
    end

    rst = 1; load = 1; en = 1; load_data = 8'hA5;
    tick();
    chk("R1 reset beats load", q, 1);
    rst = 0; load = 0; en = 0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule